// File: doc/BRIEF.md
# Two-Channel Serial Audio Master Transmitter

This block turns parallel stereo samples into a three-wire serial audio stream and is the clock master of that stream. It divides the system clock down to a bit clock. It drives a channel-select line that is low while the left sample is on the wire and high while the right sample is on the wire. It shifts each sample out most significant bit first, in two's complement, on a single data line. All three outputs come from registers clocked by the system clock.

The application side presents a left bus and a right bus. Each bus has its own one-cycle valid strobe, and a strobe copies its bus into that channel's holding register. At the start of each channel slot, the holding register is copied into the output shifter. A sample that arrives while its channel is on the wire therefore waits for the next slot of that channel. A channel whose register is not refreshed sends its last value again.

The sample width (8 to 32 bits, default 16) and the division ratio (an even number, at least 2) are parameters.

Top module: `i2s_master_tx`

## Requirements
- R1: While reset is high and in the cycle after it falls, the bit clock, channel-select and data outputs are all low. Reset clears both holding registers, so every word sent after reset is zero until a channel is strobed.
- R2: The bit clock has a period of CLK_DIV system cycles. It is high for CLK_DIV/2 cycles and low for CLK_DIV/2 cycles.
- R3: Channel-select and data change only on the system clock edge at which the bit clock goes from high to low.
- R4: Channel-select low means left and high means right. Each level of channel-select lasts exactly DATA_W bit-clock periods.
- R5: The MSB of a word is driven on the first bit-clock fall after channel-select changes. The remaining bits follow in order of falling significance. The LSB is driven on the fall at which channel-select changes again.
- R6: A slot sends the value its holding register had before the system edge on which channel-select changes to that channel. A strobe captured on that edge, or later during the slot, first appears in the next slot of the same channel.
- R7: When a channel receives no strobe, each of its slots repeats the last held value.
- R8: A left strobe never alters what is sent in right slots, and a right strobe never alters what is sent in left slots.
- R9: After reset is released, the first bit-clock fall comes at the CLK_DIV-th system edge. On that edge channel-select goes high and the right holding register is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| left_data_i | input | DATA_W | Left sample, two's complement |
| left_vld_i | input | 1 | One-cycle strobe that captures left_data_i |
| right_data_i | input | DATA_W | Right sample, two's complement |
| right_vld_i | input | 1 | One-cycle strobe that captures right_data_i |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Channel select: 0 left, 1 right |
| sd_o | output | 1 | Serial data, MSB first |

## Verification
The hardest case to reach from the ports is a strobe that lands on the very system edge where the shifter loads that same channel. The outcome is decided inside a single cycle. The stimulus watches for a channel-select change and then counts exactly one half-frame of system cycles. This places the strobe for the channel about to start on the load edge itself. A second directed strobe lands in the middle of its own channel's slot. The scoreboard builds its expected words from values that take effect only after the capturing edge, so both cases must show up one slot late.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    function automatic chan_e other_chan(input chan_e c);
        return (c == CH_LEFT) ? CH_RIGHT : CH_LEFT;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div
    import i2s_tx_pkg::*;
#(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic bclk_o,
    output logic fall_o
);
    localparam int unsigned HALF  = CLK_DIV / 2;
    localparam int unsigned CNT_W = cnt_bits(HALF);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             bclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else if (cnt_q == TERM) begin
            cnt_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign bclk_o = bclk_q;
    assign fall_o = bclk_q && (cnt_q == TERM);

    // R2
    fall_low_chk: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !bclk_o);

endmodule

// File: rtl/i2s_chan_hold.sv
module i2s_chan_hold #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] q_o
);
    logic [DATA_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)       q_r <= '0;
        else if (ld_i) q_r <= din_i;
    end

    assign q_o = q_r;

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_i |=> $stable(q_o));

endmodule

// File: rtl/i2s_frame_shifter.sv
module i2s_frame_shifter
    import i2s_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    input  logic [DATA_W-1:0] left_i,
    input  logic [DATA_W-1:0] right_i,
    output logic              ws_o,
    output logic              sd_o
);
    localparam int unsigned POS_W = cnt_bits(DATA_W);
    localparam logic [POS_W-1:0] LAST = POS_W'(DATA_W - 1);

    chan_e             ws_q;
    logic [POS_W-1:0]  pos_q;
    logic [DATA_W-1:0] sh_q;
    logic              sd_q;
    chan_e             nxt_ch;
    logic [DATA_W-1:0] nxt_word;

    always_comb begin
        nxt_ch   = other_chan(ws_q);
        nxt_word = (nxt_ch == CH_LEFT) ? left_i : right_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_q  <= CH_LEFT;
            pos_q <= LAST;
            sh_q  <= '0;
            sd_q  <= 1'b0;
        end else if (fall_i) begin
            sd_q <= sh_q[DATA_W-1];
            if (pos_q == LAST) begin
                ws_q  <= nxt_ch;
                pos_q <= '0;
                sh_q  <= nxt_word;
            end else begin
                pos_q <= pos_q + 1'b1;
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign ws_o = ws_q;
    assign sd_o = sd_q;

    // R4
    slot_start_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws_o) |-> (pos_q == '0));

endmodule

// File: rtl/i2s_master_tx.sv
module i2s_master_tx
    import i2s_tx_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] left_data_i,
    input  logic              left_vld_i,
    input  logic [DATA_W-1:0] right_data_i,
    input  logic              right_vld_i,
    output logic              bclk_o,
    output logic              ws_o,
    output logic              sd_o
);
    logic                          fall_w;
    logic [1:0]                    ld_w;
    logic [1:0][DATA_W-1:0]        din_w;
    logic [1:0][DATA_W-1:0]        held_w;

    assign ld_w[CH_LEFT]   = left_vld_i;
    assign ld_w[CH_RIGHT]  = right_vld_i;
    assign din_w[CH_LEFT]  = left_data_i;
    assign din_w[CH_RIGHT] = right_data_i;

    i2s_bclk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk    (clk),
        .rst    (rst),
        .bclk_o (bclk_o),
        .fall_o (fall_w)
    );

    for (genvar c = 0; c < 2; c++) begin : g_hold
        i2s_chan_hold #(.DATA_W(DATA_W)) u_hold (
            .clk   (clk),
            .rst   (rst),
            .ld_i  (ld_w[c]),
            .din_i (din_w[c]),
            .q_o   (held_w[c])
        );
    end

    i2s_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .fall_i  (fall_w),
        .left_i  (held_w[CH_LEFT]),
        .right_i (held_w[CH_RIGHT]),
        .ws_o    (ws_o),
        .sd_o    (sd_o)
    );

    // R1
    reset_out_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bclk_o && !ws_o && !sd_o));

    // R3
    ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws_o) |-> $fell(bclk_o));

    // R3
    sd_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_o) |-> $fell(bclk_o));

endmodule

// File: tb/sim_i2s_master_tx.sv
module sim_i2s_master_tx;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 16;
    localparam int DIV   = 4;
    localparam int HALF  = DIV / 2;
    localparam int SLOT  = W * DIV;
    localparam int FRAME = 2 * SLOT;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] ldat = '0, rdat = '0;
    logic         lvld = 1'b0, rvld = 1'b0;
    logic         bclk_o, ws_o, sd_o;

    int    n_run = 0, n_fail = 0, n_words = 0;
    string cur_req = "R1";
    logic [W-1:0] model_l = '0, model_r = '0;
    logic [W:0]   expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_master_tx #(.DATA_W(W), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst),
        .left_data_i(ldat), .left_vld_i(lvld),
        .right_data_i(rdat), .right_vld_i(rvld),
        .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor and scoreboard
    logic         prev_bclk = 1'b0, ws_neg_prev = 1'b0, ws_at_rise = 1'b0;
    logic         started = 1'b0, trk = 1'b0;
    logic [W-2:0] shw = '0;
    int           rises = 0, run = 0;
    always @(negedge clk) begin
        if (rst) begin
            expq.delete();
            prev_bclk = 0; ws_neg_prev = 0; ws_at_rise = 0;
            started = 0; trk = 0; shw = '0; rises = 0; run = 0;
        end else begin
            if (ws_o != ws_neg_prev)
                expq.push_back({ws_o, ws_o ? model_r : model_l});
            ws_neg_prev = ws_o;
            if (bclk_o != prev_bclk) begin
                if (trk) chk(run == HALF, "R2", "bclk level length", run, HALF);
                run = 1;
                trk = started;
            end else run++;
            if (bclk_o && !prev_bclk) begin
                if (ws_o != ws_at_rise) begin
                    if (started) begin
                        logic [W:0] e;
                        logic [W-1:0] got;
                        got = {shw, sd_o};
                        chk(rises == W, "R4", "bits per ws level", rises, W);
                        if (expq.size() == 0) begin
                            chk(0, cur_req, "word with no expectation", got, 0);
                        end else begin
                            e = expq.pop_front();
                            n_words++;
                            chk(e[W] == ws_at_rise, "R4", "channel of word", ws_at_rise, e[W]);
                            chk(got == e[W-1:0], cur_req, "serial word", got, e[W-1:0]);
                        end
                    end
                    started = 1; shw = '0; rises = 1;
                end else begin
                    shw = {shw[W-3:0], sd_o};
                    rises++;
                end
                ws_at_rise = ws_o;
            end
            prev_bclk = bclk_o;
        end
    end

    task automatic strobe(input bit ch, input logic [W-1:0] v);
        @(negedge clk);
        if (ch) begin rdat = v; rvld = 1'b1; end
        else    begin ldat = v; lvld = 1'b1; end
        @(negedge clk);
        lvld = 1'b0; rvld = 1'b0;
        if (ch) model_r <= v; else model_l <= v;
    endtask

    task automatic do_reset();
        int n;
        @(negedge clk);
        rst = 1'b1;
        model_l <= '0; model_r <= '0;
        repeat (3) @(negedge clk);
        // R1 outputs low in reset
        chk({bclk_o, ws_o, sd_o} == 3'b000, "R1", "outputs in reset", {bclk_o, ws_o, sd_o}, 0);
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!ws_o && n < 50);
        // R9 first fall loads right at edge CLK_DIV
        chk(n == DIV, "R9", "edges to first ws rise", n, DIV);
    endtask

    task automatic wait_ws_change();
        logic w0;
        w0 = ws_o;
        do @(negedge clk); while (ws_o == w0);
    endtask

    initial begin
        cur_req = "R1";
        do_reset();
        repeat (3 * FRAME) @(negedge clk);

        cur_req = "R5";
        strobe(0, 16'h8001);
        strobe(1, 16'h7FFE);
        repeat (2 * FRAME) @(negedge clk);
        strobe(0, 16'hA5C3);
        strobe(1, 16'hFFFF);
        repeat (2 * FRAME) @(negedge clk);

        cur_req = "R7";
        repeat (4 * FRAME) @(negedge clk);

        cur_req = "R8";
        for (int i = 0; i < 4; i++) begin
            strobe(0, 16'h1111 * (i + 1));
            repeat (FRAME) @(negedge clk);
        end
        strobe(1, 16'h0F0F);
        repeat (2 * FRAME) @(negedge clk);

        cur_req = "R6";
        // strobe captured on the exact load edge of the next channel
        for (int k = 0; k < 2; k++) begin
            wait_ws_change();
            repeat (SLOT - 2) @(negedge clk);
            strobe(!ws_o, k ? 16'h3C3C : 16'hC001);
            repeat (2 * FRAME) @(negedge clk);
        end
        // strobe in the middle of its own channel's slot
        wait_ws_change();
        repeat (SLOT / 2) @(negedge clk);
        strobe(ws_o, 16'h5A5A);
        repeat (2 * FRAME) @(negedge clk);

        cur_req = "R1";
        do_reset();
        repeat (3 * FRAME) @(negedge clk);

        chk(n_words > 40, "R5", "words compared", n_words, 40);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule